// File: doc/BRIEF.md
# Event Interrupt Aggregator

This block gathers events from across a chip and turns them into interrupt lines that a host can act on. Local discrete interrupt lines are converted into numbered global events, each line using either single-cycle pulse detection or rising-edge detection. These events leave on the first egress event lane. Numbered global events arrive on an ingress lane. There, programmable counters tally the events that match their configured numbers, and multicast entries copy one matching ingress event into two new events, one on each egress lane.

Each counter raises a status bit when it leaves zero. Every host interrupt output is the OR of the status bits that the host's own mask enables. Status bits are write-1-to-clear. All configuration is held in 64-bit registers on a simple word-addressed read/write port. A write takes effect at the clock edge, and a read returns data combinationally from the address.

Every lane transfer is a valid strobe with an event number plus a ready signal. Each egress lane drains a small FIFO. The ingress lane is back-pressured whenever either FIFO is full.

Top module: `evt_agg`

## Requirements
- R1: After reset, all registers read zero, both egress lanes are idle, `host_irq` is zero and `ing_ready` is 1.
- R2: A local line in edge mode (bit 16 of its config word at address 0x10+i set, bit 17 enable) emits its event number (bits 7:0) exactly once per rising edge, however long the line stays high.
- R3: A local line in pulse mode (bit 16 clear) emits one event for each cycle it is sampled high; a single-cycle pulse gives exactly one event. A line whose enable bit 17 is clear emits nothing. Detections on a line that still has an event waiting are merged into that event.
- R4: Local events leave on egress lane 0 carrying the programmed number. Lane 0 takes at most one new event per cycle. A multicast copy has priority over a local event, and among local lines the lowest index goes first.
- R5: A multicast entry at address 0x20+m holds an ingress number (bits 7:0), a lane-0 number (bits 23:16), a lane-1 number (bits 39:32) and an enable (bit 48). An accepted ingress event that matches an enabled entry pushes both output numbers onto their lanes at the same edge. The lowest matching entry wins, and an event that matches no entry produces no egress event.
- R6: `ing_ready` is low while either egress FIFO is full. An egress lane holds its valid signal and event number steady until ready is high. Nothing is ever pushed into a full FIFO.
- R7: A counter configured at address 0x30+c (match number bits 7:0, enable bit 16) increments by one for each accepted matching ingress event. Its value reads back at address 0x38+c, and a disabled counter does not change.
- R8: A counter saturates at 2^CNT_W-1 and stays there.
- R9: Status (address 0x00, bit c for counter c) is set when counter c goes from zero to nonzero. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear. A counter that is already nonzero sets nothing.
- R10: `host_irq[h]` is high exactly when status ANDed with the mask at address 0x08+h (bit c enables counter c) is nonzero.
- R11: Any write to a counter's value address clears that counter to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_irq | input | N_LOCAL | Local discrete interrupt lines |
| ing_valid | input | 1 | Ingress event strobe |
| ing_evt | input | EVT_W | Ingress event number |
| ing_ready | output | 1 | Ingress can accept |
| eg0_valid | output | 1 | Egress lane 0 event strobe |
| eg0_evt | output | EVT_W | Egress lane 0 event number |
| eg0_ready | input | 1 | Egress lane 0 sink ready |
| eg1_valid | output | 1 | Egress lane 1 event strobe |
| eg1_evt | output | EVT_W | Egress lane 1 event number |
| eg1_ready | input | 1 | Egress lane 1 sink ready |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data |
| host_irq | output | N_HOST | Host interrupt outputs |

## Verification
An ingress event accepted at one edge is visible after that same edge in three places: the egress FIFO outputs (multicast copies), the counter values, and the status bits with `host_irq`. A local line sampled high at one edge reaches lane 0 one edge later, because its pending flag sits in front of the FIFO. Register reads are combinational, and register writes land at the next edge. The bench drives inputs on the falling edge and samples 1 ns after it. Lane transfers are counted per event number at that point. Every directed check waits out the full latency, plus enough idle cycles for the FIFOs to drain, before it compares against the bench's own model.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;
  // Word addresses of the register groups
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_MASK   = 8;
  localparam int unsigned ADDR_LOCAL  = 16;
  localparam int unsigned ADDR_MCAST  = 32;
  localparam int unsigned ADDR_CCFG   = 48;
  localparam int unsigned ADDR_CVAL   = 56;

  // Field positions inside configuration words
  localparam int unsigned LOC_EDGE_BIT = 16;
  localparam int unsigned LOC_EN_BIT   = 17;
  localparam int unsigned MC_OUT0_LSB  = 16;
  localparam int unsigned MC_OUT1_LSB  = 32;
  localparam int unsigned MC_EN_BIT    = 48;
  localparam int unsigned CNT_EN_BIT   = 16;

  // Saturating increment for a counter of width w (w <= 32)
  function automatic logic [31:0] sat_step(logic [31:0] v, int unsigned w);
    logic [31:0] top;
    top = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return (v >= top) ? top : v + 32'd1;
  endfunction

  // Detection rule for one local line
  function automatic logic local_fire(logic cur, logic prev, logic edge_mode, logic en);
    return en & (edge_mode ? (cur & ~prev) : cur);
  endfunction
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic         valid,
  output logic [W-1:0] dout
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign valid   = (count != '0);
  assign dout    = mem[rd_ptr];
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      if (do_push && !do_pop)      count <= count + CNT_W'(1);
      else if (do_pop && !do_push) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/local_conv.sv
module local_conv import evt_agg_pkg::*; #(
  parameter int unsigned N     = 4,
  parameter int unsigned EVT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N-1:0]            irq,
  input  logic [N-1:0]            en,
  input  logic [N-1:0]            edge_mode,
  input  logic [N-1:0][EVT_W-1:0] evt_num,
  input  logic                    slot_free,
  output logic                    push,
  output logic [EVT_W-1:0]        push_evt,
  output logic [N-1:0]            fire
);
  logic [N-1:0] prev_q, pend_q, grant;

  always_comb begin
    for (int i = 0; i < N; i++) fire[i] = local_fire(irq[i], prev_q[i], edge_mode[i], en[i]);
  end

  // lowest pending line wins the lane-0 slot
  always_comb begin
    logic found;
    found    = 1'b0;
    grant    = '0;
    push_evt = '0;
    for (int i = 0; i < N; i++) begin
      if (slot_free && pend_q[i] && !found) begin
        found    = 1'b1;
        grant[i] = 1'b1;
        push_evt = evt_num[i];
      end
    end
  end

  assign push = |grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= irq;
      pend_q <= (pend_q & ~grant) | fire;
    end
  end
endmodule

// File: rtl/mcast_match.sv
module mcast_match #(
  parameter int unsigned M     = 2,
  parameter int unsigned EVT_W = 8
) (
  input  logic [M-1:0][EVT_W-1:0] in_num,
  input  logic [M-1:0][EVT_W-1:0] out0_num,
  input  logic [M-1:0][EVT_W-1:0] out1_num,
  input  logic [M-1:0]            en,
  input  logic [EVT_W-1:0]        evt,
  output logic                    hit,
  output logic [EVT_W-1:0]        out0,
  output logic [EVT_W-1:0]        out1
);
  always_comb begin
    hit  = 1'b0;
    out0 = '0;
    out1 = '0;
    for (int m = 0; m < M; m++) begin
      if (!hit && en[m] && (in_num[m] == evt)) begin
        hit  = 1'b1;
        out0 = out0_num[m];
        out1 = out1_num[m];
      end
    end
  end
endmodule

// File: rtl/evt_counters.sv
module evt_counters import evt_agg_pkg::*; #(
  parameter int unsigned C     = 4,
  parameter int unsigned EVT_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [EVT_W-1:0]        evt,
  input  logic [C-1:0][EVT_W-1:0] match,
  input  logic [C-1:0]            en,
  input  logic [C-1:0]            clr,
  output logic [C-1:0][CNT_W-1:0] val,
  output logic [C-1:0]            rise
);
  logic [C-1:0] inc;

  always_comb begin
    for (int c = 0; c < C; c++) begin
      inc[c]  = accept && en[c] && (match[c] == evt);
      rise[c] = inc[c] && !clr[c] && (val[c] == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else begin
      for (int c = 0; c < C; c++) begin
        if (clr[c])      val[c] <= '0;
        else if (inc[c]) val[c] <= CNT_W'(sat_step(32'(val[c]), CNT_W));
      end
    end
  end
endmodule

// File: rtl/evt_agg.sv
module evt_agg import evt_agg_pkg::*; #(
  parameter int unsigned N_LOCAL    = 4,
  parameter int unsigned N_MCAST    = 2,
  parameter int unsigned N_CNT      = 4,
  parameter int unsigned N_HOST     = 2,
  parameter int unsigned EVT_W      = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned ADDR_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LOCAL-1:0] local_irq,
  input  logic               ing_valid,
  input  logic [EVT_W-1:0]   ing_evt,
  output logic               ing_ready,
  output logic               eg0_valid,
  output logic [EVT_W-1:0]   eg0_evt,
  input  logic               eg0_ready,
  output logic               eg1_valid,
  output logic [EVT_W-1:0]   eg1_evt,
  input  logic               eg1_ready,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic [N_HOST-1:0]  host_irq
);
  // configuration state
  logic [N_HOST-1:0][N_CNT-1:0]   mask_q;
  logic [N_LOCAL-1:0][EVT_W-1:0]  loc_num_q;
  logic [N_LOCAL-1:0]             loc_edge_q, loc_en_q;
  logic [N_MCAST-1:0][EVT_W-1:0]  mc_in_q, mc_o0_q, mc_o1_q;
  logic [N_MCAST-1:0]             mc_en_q;
  logic [N_CNT-1:0][EVT_W-1:0]    cm_evt_q;
  logic [N_CNT-1:0]               cm_en_q;
  logic [N_CNT-1:0]               status_q;

  // named internal events
  logic                           accept, mc_hit, mc_take;
  logic [EVT_W-1:0]               mc_out0, mc_out1;
  logic                           loc_push;
  logic [EVT_W-1:0]               loc_evt;
  logic [N_LOCAL-1:0]             loc_fire;
  logic                           lane0_push, lane0_full, lane1_push, lane1_full;
  logic [EVT_W-1:0]               lane0_din;
  logic [N_CNT-1:0][CNT_W-1:0]    cnt_val;
  logic [N_CNT-1:0]               cnt_rise, cnt_clr;
  logic [N_CNT-1:0]               status_w1c;
  logic                           unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // ingress and lane steering
  assign ing_ready  = !lane0_full && !lane1_full;
  assign accept     = ing_valid && ing_ready;
  assign mc_take    = accept && mc_hit;
  assign lane0_push = mc_take || loc_push;
  assign lane0_din  = mc_take ? mc_out0 : loc_evt;
  assign lane1_push = mc_take;

  local_conv #(.N(N_LOCAL), .EVT_W(EVT_W)) u_loc (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (local_irq),
    .en        (loc_en_q),
    .edge_mode (loc_edge_q),
    .evt_num   (loc_num_q),
    .slot_free (!lane0_full && !mc_take),
    .push      (loc_push),
    .push_evt  (loc_evt),
    .fire      (loc_fire)
  );

  mcast_match #(.M(N_MCAST), .EVT_W(EVT_W)) u_mc (
    .in_num   (mc_in_q),
    .out0_num (mc_o0_q),
    .out1_num (mc_o1_q),
    .en       (mc_en_q),
    .evt      (ing_evt),
    .hit      (mc_hit),
    .out0     (mc_out0),
    .out1     (mc_out1)
  );

  evt_counters #(.C(N_CNT), .EVT_W(EVT_W), .CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .evt    (ing_evt),
    .match  (cm_evt_q),
    .en     (cm_en_q),
    .clr    (cnt_clr),
    .val    (cnt_val),
    .rise   (cnt_rise)
  );

  evt_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_lane0 (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (lane0_push),
    .din   (lane0_din),
    .full  (lane0_full),
    .pop   (eg0_ready),
    .valid (eg0_valid),
    .dout  (eg0_evt)
  );

  evt_fifo #(.W(EVT_W), .DEPTH(FIFO_DEPTH)) u_lane1 (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (lane1_push),
    .din   (mc_out1),
    .full  (lane1_full),
    .pop   (eg1_ready),
    .valid (eg1_valid),
    .dout  (eg1_evt)
  );

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      loc_num_q  <= '0;
      loc_edge_q <= '0;
      loc_en_q   <= '0;
      mc_in_q    <= '0;
      mc_o0_q    <= '0;
      mc_o1_q    <= '0;
      mc_en_q    <= '0;
      cm_evt_q   <= '0;
      cm_en_q    <= '0;
    end else if (reg_wr) begin
      for (int h = 0; h < N_HOST; h++)
        if (reg_addr == ADDR_W'(ADDR_MASK + h)) mask_q[h] <= reg_wdata[N_CNT-1:0];
      for (int i = 0; i < N_LOCAL; i++)
        if (reg_addr == ADDR_W'(ADDR_LOCAL + i)) begin
          loc_num_q[i]  <= reg_wdata[EVT_W-1:0];
          loc_edge_q[i] <= reg_wdata[LOC_EDGE_BIT];
          loc_en_q[i]   <= reg_wdata[LOC_EN_BIT];
        end
      for (int m = 0; m < N_MCAST; m++)
        if (reg_addr == ADDR_W'(ADDR_MCAST + m)) begin
          mc_in_q[m] <= reg_wdata[EVT_W-1:0];
          mc_o0_q[m] <= reg_wdata[MC_OUT0_LSB +: EVT_W];
          mc_o1_q[m] <= reg_wdata[MC_OUT1_LSB +: EVT_W];
          mc_en_q[m] <= reg_wdata[MC_EN_BIT];
        end
      for (int c = 0; c < N_CNT; c++)
        if (reg_addr == ADDR_W'(ADDR_CCFG + c)) begin
          cm_evt_q[c] <= reg_wdata[EVT_W-1:0];
          cm_en_q[c]  <= reg_wdata[CNT_EN_BIT];
        end
    end
  end

  always_comb begin
    for (int c = 0; c < N_CNT; c++) cnt_clr[c] = reg_wr && (reg_addr == ADDR_W'(ADDR_CVAL + c));
    status_w1c = (reg_wr && reg_addr == ADDR_W'(ADDR_STATUS)) ? reg_wdata[N_CNT-1:0] : '0;
  end

  // status: set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~status_w1c) | cnt_rise;
  end

  always_comb begin
    for (int h = 0; h < N_HOST; h++) host_irq[h] = |(status_q & mask_q[h]);
  end

  // register reads
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_STATUS)) reg_rdata[N_CNT-1:0] = status_q;
    for (int h = 0; h < N_HOST; h++)
      if (reg_addr == ADDR_W'(ADDR_MASK + h)) reg_rdata[N_CNT-1:0] = mask_q[h];
    for (int i = 0; i < N_LOCAL; i++)
      if (reg_addr == ADDR_W'(ADDR_LOCAL + i)) begin
        reg_rdata[EVT_W-1:0]    = loc_num_q[i];
        reg_rdata[LOC_EDGE_BIT] = loc_edge_q[i];
        reg_rdata[LOC_EN_BIT]   = loc_en_q[i];
      end
    for (int m = 0; m < N_MCAST; m++)
      if (reg_addr == ADDR_W'(ADDR_MCAST + m)) begin
        reg_rdata[EVT_W-1:0]             = mc_in_q[m];
        reg_rdata[MC_OUT0_LSB +: EVT_W]  = mc_o0_q[m];
        reg_rdata[MC_OUT1_LSB +: EVT_W]  = mc_o1_q[m];
        reg_rdata[MC_EN_BIT]             = mc_en_q[m];
      end
    for (int c = 0; c < N_CNT; c++) begin
      if (reg_addr == ADDR_W'(ADDR_CCFG + c)) begin
        reg_rdata[EVT_W-1:0]  = cm_evt_q[c];
        reg_rdata[CNT_EN_BIT] = cm_en_q[c];
      end
      if (reg_addr == ADDR_W'(ADDR_CVAL + c)) reg_rdata[CNT_W-1:0] = cnt_val[c];
    end
  end
endmodule

// File: rtl/evt_agg_chk.sv
module evt_agg_chk #(
  parameter int unsigned N_CNT  = 4,
  parameter int unsigned N_HOST = 2,
  parameter int unsigned EVT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lane0_push,
  input logic              lane0_full,
  input logic              lane1_push,
  input logic              lane1_full,
  input logic              mc_take,
  input logic              eg0_valid,
  input logic              eg0_ready,
  input logic [EVT_W-1:0]  eg0_evt,
  input logic [N_CNT-1:0]  status_q,
  input logic [N_CNT-1:0]  cnt_rise,
  input logic [N_HOST-1:0] host_irq
);
  // R6
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lane0_push && lane0_full) && !(lane1_push && lane1_full));

  // R5
  mcast_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_take |-> (lane0_push && lane1_push));

  // R6
  egress_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eg0_valid && !eg0_ready) |=> (eg0_valid && $stable(eg0_evt)));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0) |-> (host_irq == '0));

  // R9
  status_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cnt_rise) |=> ((status_q & $past(cnt_rise)) == $past(cnt_rise)));
endmodule

bind evt_agg evt_agg_chk #(.N_CNT(N_CNT), .N_HOST(N_HOST), .EVT_W(EVT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lane0_push (lane0_push),
  .lane0_full (lane0_full),
  .lane1_push (lane1_push),
  .lane1_full (lane1_full),
  .mc_take    (mc_take),
  .eg0_valid  (eg0_valid),
  .eg0_ready  (eg0_ready),
  .eg0_evt    (eg0_evt),
  .status_q   (status_q),
  .cnt_rise   (cnt_rise),
  .host_irq   (host_irq)
);

// File: tb/test_evt_agg.sv
`timescale 1ns/1ps
module test_evt_agg;
  localparam real CLK_NS = 4.0;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  local_irq = '0;
  logic        ing_valid = 0;
  logic [7:0]  ing_evt = '0;
  logic        ing_ready;
  logic        eg0_valid, eg1_valid;
  logic [7:0]  eg0_evt, eg1_evt;
  logic        eg0_ready = 1, eg1_ready = 1;
  logic        reg_wr = 0;
  logic [5:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [1:0]  host_irq;

  int n_chk = 0, n_fail = 0;
  int seen0 [256];
  int seen1 [256];

  always #(CLK_NS/2) clk = ~clk;

  evt_agg i_evt_agg (
    .clk(clk), .rst_n(rst_n), .local_irq(local_irq),
    .ing_valid(ing_valid), .ing_evt(ing_evt), .ing_ready(ing_ready),
    .eg0_valid(eg0_valid), .eg0_evt(eg0_evt), .eg0_ready(eg0_ready),
    .eg1_valid(eg1_valid), .eg1_evt(eg1_evt), .eg1_ready(eg1_ready),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // lane monitor: a transfer is valid && ready seen just after the falling edge
  always @(negedge clk) begin
    #1;
    if (eg0_valid && eg0_ready) seen0[eg0_evt]++;
    if (eg1_valid && eg1_ready) seen1[eg1_evt]++;
  end

  function automatic logic [63:0] loc_word(logic [7:0] num, logic edge_m, logic en);
    return {46'd0, en, edge_m, 8'd0, num};
  endfunction
  function automatic logic [63:0] mc_word(logic [7:0] inn, logic [7:0] o0, logic [7:0] o1, logic en);
    logic [63:0] w;
    w = '0; w[7:0] = inn; w[23:16] = o0; w[39:32] = o1; w[48] = en;
    return w;
  endfunction
  function automatic logic [63:0] cc_word(logic [7:0] num, logic en);
    return {47'd0, en, 8'd0, num};
  endfunction
  function automatic int sat_model(int n, int w);
    int top;
    top = (1 << w) - 1;
    return (n > top) ? top : n;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input logic [7:0] e);
    @(negedge clk);
    ing_valid = 1; ing_evt = e;
    while (!ing_ready) begin
      eg0_ready = 1; eg1_ready = 1;
      @(negedge clk);
    end
    @(negedge clk);
    ing_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_seen();
    for (int k = 0; k < 256; k++) begin seen0[k] = 0; seen1[k] = 0; end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] d;
    int m50, m60, m70;
    clear_seen();
    void'($urandom(32'd1957));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    // R1 reset state
    check("R1 host_irq", 64'(host_irq), 0);
    check("R1 eg0_valid", 64'(eg0_valid), 0);
    check("R1 eg1_valid", 64'(eg1_valid), 0);
    check("R1 ing_ready", 64'(ing_ready), 1);
    rd(6'h00, d); check("R1 status", d, 0);
    rd(6'h38, d); check("R1 count0", d, 0);
    rd(6'h10, d); check("R1 local cfg", d, 0);

    // R2 / R3: local conversion
    wr(6'h10, loc_word(8'h11, 1, 1));
    wr(6'h11, loc_word(8'h22, 0, 1));
    wr(6'h12, loc_word(8'h33, 1, 0));
    rd(6'h10, d); check("R2 cfg readback", d, loc_word(8'h11, 1, 1));
    @(negedge clk);
    local_irq[0] = 1; local_irq[2] = 1;
    for (int p = 0; p < 3; p++) begin
      local_irq[1] = 1;
      @(negedge clk);
      local_irq[1] = 0;
      idle(3);
    end
    local_irq[2] = 0;
    idle(8);
    check("R2 held edge line once", 64'(seen0[8'h11]), 1);
    check("R3 pulse count", 64'(seen0[8'h22]), 3);
    check("R3 disabled line silent", 64'(seen0[8'h33]), 0);
    local_irq[0] = 0; idle(2); local_irq[0] = 1; idle(6);
    check("R2 second rising edge", 64'(seen0[8'h11]), 2);
    check("R4 lane1 untouched by locals", 64'(seen1[8'h11] + seen1[8'h22]), 0);
    local_irq = '0;
    idle(4);

    // R5: multicast, entry 0 has priority over entry 1
    clear_seen();
    wr(6'h20, mc_word(8'h40, 8'h41, 8'h42, 1));
    wr(6'h21, mc_word(8'h40, 8'h51, 8'h52, 1));
    send(8'h40);
    idle(4);
    check("R5 lane0 copy", 64'(seen0[8'h41]), 1);
    check("R5 lane1 copy", 64'(seen1[8'h42]), 1);
    check("R5 lower entry loses", 64'(seen0[8'h51] + seen1[8'h52]), 0);
    send(8'h43);
    idle(4);
    check("R5 no match no output", 64'(seen0[8'h41] + seen1[8'h42]), 2);

    // R6: back-pressure from lane 1
    clear_seen();
    eg1_ready = 0;
    for (int k = 0; k < 4; k++) send(8'h40);
    @(negedge clk);
    ing_valid = 1; ing_evt = 8'h40;
    #1;
    check("R6 ready low when full", 64'(ing_ready), 0);
    check("R6 lane1 holds", 64'(eg1_valid), 1);
    check("R6 lane1 value", 64'(eg1_evt), 64'h42);
    idle(2);
    check("R6 still blocked", 64'(ing_ready), 0);
    eg1_ready = 1;
    while (!ing_ready) @(negedge clk);
    @(negedge clk);
    ing_valid = 0;
    idle(8);
    check("R6 all lane1 copies delivered", 64'(seen1[8'h42]), 5);
    check("R6 all lane0 copies delivered", 64'(seen0[8'h41]), 5);

    // R7 / R9 / R10 / R11: counter, status, interrupt
    wr(6'h30, cc_word(8'h50, 1));
    wr(6'h08, 64'h1);
    wr(6'h09, 64'h2);
    #1;
    check("R10 quiet before event", 64'(host_irq), 0);
    send(8'h50);
    #1;
    check("R10 host0 raised", 64'(host_irq), 64'b01);
    rd(6'h00, d); check("R9 status set", d, 1);
    rd(6'h38, d); check("R7 count one", d, 1);
    wr(6'h00, 64'h0);
    rd(6'h00, d); check("R9 zero write keeps", d, 1);
    wr(6'h00, 64'h1);
    rd(6'h00, d); check("R9 w1c clears", d, 0);
    #1;
    check("R10 host cleared", 64'(host_irq), 0);
    send(8'h50);
    rd(6'h00, d); check("R9 nonzero count no reset", d, 0);
    rd(6'h38, d); check("R7 count two", d, 2);
    wr(6'h38, 64'hFFFF);
    rd(6'h38, d); check("R11 write clears", d, 0);
    send(8'h50);
    rd(6'h00, d); check("R9 rearmed", d, 1);
    wr(6'h09, 64'h1);
    #1;
    check("R10 both hosts", 64'(host_irq), 64'b11);
    wr(6'h00, 64'hF);

    // R7 random traffic against a bench model
    clear_seen();
    wr(6'h20, mc_word(8'h70, 8'h71, 8'h72, 1));
    wr(6'h21, mc_word(8'h40, 8'h51, 8'h52, 0));
    wr(6'h31, cc_word(8'h60, 1));
    wr(6'h32, cc_word(8'h70, 1));
    wr(6'h33, cc_word(8'h50, 0));
    for (int c = 0; c < 4; c++) wr(6'(8'h38 + c), 64'h0);
    m50 = 0; m60 = 0; m70 = 0;
    for (int k = 0; k < 200; k++) begin
      int sel;
      logic [7:0] e;
      sel = $urandom_range(3, 0);
      case (sel)
        0: e = 8'h50;
        1: e = 8'h60;
        2: e = 8'h70;
        default: e = 8'h80 + 8'($urandom_range(15, 0));
      endcase
      if (e == 8'h50) m50++;
      if (e == 8'h60) m60++;
      if (e == 8'h70) m70++;
      eg0_ready = 1'($urandom_range(1, 0));
      eg1_ready = 1'($urandom_range(1, 0));
      send(e);
    end
    eg0_ready = 1; eg1_ready = 1;
    idle(12);
    rd(6'h38, d); check("R7 random count 0x50", d, 64'(sat_model(m50, 8)));
    rd(6'h39, d); check("R7 random count 0x60", d, 64'(sat_model(m60, 8)));
    rd(6'h3A, d); check("R7 random count 0x70", d, 64'(sat_model(m70, 8)));
    rd(6'h3B, d); check("R7 disabled counter", d, 0);
    check("R5 random lane0 copies", 64'(seen0[8'h71]), 64'(m70));
    check("R5 random lane1 copies", 64'(seen1[8'h72]), 64'(m70));

    // R8 saturation
    wr(6'h38, 64'h0);
    for (int k = 0; k < 300; k++) send(8'h50);
    rd(6'h38, d); check("R8 saturates", d, 64'(sat_model(300, 8)));
    send(8'h50);
    rd(6'h38, d); check("R8 stays at top", d, 64'hFF);

    summary();
    $finish;
  end
endmodule